// File: doc/BRIEF.md
# Scoreboard Dispatch/Issue/Writeback Controller

This block is the central control of a scoreboard-scheduled out-of-order pipeline. It has no register renaming and no bypassing. It governs five functional units: an integer ALU, a load unit, a store unit and two floating-point units. A front end offers one decoded instruction per cycle: its unit class, an opcode, a destination name and two source names.

The controller keeps a status row for every unit and a producer tag for every architectural register. From these it decides three things each cycle. It decides whether the offered instruction may enter a unit. It decides which waiting instruction may read the register file and start executing. It decides which finished units may write their result back. Completion is reported by the units as single-cycle pulses. The floating-point units are assumed to be three-cycle pipelines, but the controller does not count latency itself.

All hazard tracking uses unit tags. Tag 0 means the value already sits in the register file; tags 1 to 5 name the ALU, load, store, first FP and second FP unit. Arithmetic, register storage, memory and fetch sit outside this block.

Top module: `scoreboard_ctrl`

## Requirements
- R1: After reset every unit is idle and every register tag is 0, so there is no issue strobe and no writeback grant.
- R2: Classes are encoded 0 ALU, 1 load, 2 store, 3 FP. A valid instruction stalls while its unit is occupied. A unit granted writeback in the same cycle counts as free. An FP instruction takes the first FP unit if free, else the second. `dispTag` reports the chosen unit tag.
- R3: An instruction that writes a register stalls while that register's tag, as held at the start of the cycle, is nonzero (write-after-write).
- R4: Tags are 0 for ready and 1 to 5 for ALU, load, store, FP1 and FP2. On acceptance each source tag is copied from its register's tag. The copy is 0 if that register's producer is written back in the same cycle.
- R5: An entry issues only when both source tags are 0, or are cleared by a writeback in that cycle. At most one issue happens per cycle, and the oldest ready entry by acceptance order wins.
- R6: With an issue strobe, `issueOp`, `issueSrc1` and `issueSrc2` carry the issuing entry's opcode and source names.
- R7: A completion pulse counts only for a unit that has issued and not yet completed. Otherwise it has no effect. A valid completion may be granted writeback in the cycle of the pulse.
- R8: A completed unit is denied writeback while another occupied, not-yet-issued entry has a source with tag 0 whose name equals its destination (write-after-read).
- R9: On writeback the unit is freed, its destination tag is cleared and every matching source tag in the table is cleared.
- R10: A store writes no register. It is never stalled by a destination tag, sets no register tag and is never held at writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dispValid | input | 1 | Decoded instruction offered |
| dispClass | input | 2 | Unit class (0 ALU, 1 load, 2 store, 3 FP) |
| dispOp | input | OP_W | Opcode carried to issue |
| dispDest | input | REG_W | Destination register name |
| dispSrc1 | input | REG_W | First source register name |
| dispSrc2 | input | REG_W | Second source register name |
| doneIn | input | 5 | Per-unit completion pulse (bit 0 ALU … bit 4 FP2) |
| dispStall | output | 1 | Offered instruction not accepted this cycle |
| dispTag | output | 3 | Unit tag chosen for the offered instruction |
| issueStrobe | output | 5 | One-hot issue strobe per unit |
| issueOp | output | OP_W | Opcode of the issuing entry |
| issueSrc1 | output | REG_W | First register read address |
| issueSrc2 | output | REG_W | Second register read address |
| wbGrant | output | 5 | Per-unit writeback grant |

## Verification
The stall, unit choice, issue strobe, read addresses and writeback grants are all answers in the same cycle to the table state and the inputs of that cycle. Table updates, such as acceptance, tag clears and freeing, appear only in the next cycle's answers. The bench drives inputs just after the falling edge. It compares every output one time step later against a behavioural model computed from the same inputs. It advances that model only after the rising edge, so each result is checked in the exact cycle it is due. Completion pulses come from a model of unit latency (1, 2, 1, 3, 3 cycles) started by the expected issue. Stray pulses are added on idle units.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int NUM_UNITS = 5;
  localparam int TAG_W     = 3;
  localparam int U_FP1     = 3;
  localparam int U_FP2     = 4;

  typedef enum logic [1:0] {
    CLS_ALU = 2'd0,
    CLS_LD  = 2'd1,
    CLS_ST  = 2'd2,
    CLS_FP  = 2'd3
  } unitClass_e;

  typedef struct packed {
    logic                 dispEn;
    logic [TAG_W-1:0]     dispIdx;
    logic [NUM_UNITS-1:0] issueOh;
    logic [NUM_UNITS-1:0] wbOh;
  } sbStrobes_t;
endpackage

// File: rtl/sb_tables.sv
module sb_tables
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int OP_W = 4,
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic clk,
  input  logic rstN,
  input  sbStrobes_t stb,
  input  logic dispIsStore,
  input  logic [OP_W-1:0] dispOp,
  input  logic [REG_W-1:0] dispDest,
  input  logic [REG_W-1:0] dispSrc1,
  input  logic [REG_W-1:0] dispSrc2,
  input  logic [NUM_UNITS-1:0] doneIn,
  output logic [NUM_UNITS-1:0] busyQ,
  output logic [NUM_UNITS-1:0] issuedQ,
  output logic [NUM_UNITS-1:0] doneQ,
  output logic [NUM_UNITS-1:0] hasDestQ,
  output logic [NUM_UNITS-1:0][OP_W-1:0] opQ,
  output logic [NUM_UNITS-1:0][REG_W-1:0] destQ,
  output logic [NUM_UNITS-1:0][REG_W-1:0] src1Q,
  output logic [NUM_UNITS-1:0][REG_W-1:0] src2Q,
  output logic [NUM_UNITS-1:0][TAG_W-1:0] tag1Q,
  output logic [NUM_UNITS-1:0][TAG_W-1:0] tag2Q,
  output logic [NUM_UNITS-1:0][NUM_UNITS-1:0] olderQ,
  output logic [TAG_W-1:0] destStat
);
  logic [TAG_W-1:0] regStat [NUM_REGS];
  logic [TAG_W-1:0] newTag1, newTag2;

  // A tag whose producer writes back this cycle is already ready.
  function automatic logic [TAG_W-1:0] liveTag(input logic [TAG_W-1:0] t,
                                               input logic [NUM_UNITS-1:0] wb);
    liveTag = t;
    for (int u = 0; u < NUM_UNITS; u++)
      if (wb[u] && t == TAG_W'(u + 1)) liveTag = '0;
  endfunction

  assign destStat = regStat[dispDest];
  assign newTag1  = liveTag(regStat[dispSrc1], stb.wbOh);
  assign newTag2  = liveTag(regStat[dispSrc2], stb.wbOh);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REGS; r++) regStat[r] <= '0;
    end else begin
      for (int u = 0; u < NUM_UNITS; u++)
        if (stb.wbOh[u] && hasDestQ[u]) regStat[destQ[u]] <= '0;
      if (stb.dispEn && !dispIsStore) regStat[dispDest] <= stb.dispIdx + TAG_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= '0; issuedQ <= '0; doneQ <= '0; hasDestQ <= '0;
      opQ <= '0; destQ <= '0; src1Q <= '0; src2Q <= '0;
      tag1Q <= '0; tag2Q <= '0; olderQ <= '0;
    end else begin
      for (int u = 0; u < NUM_UNITS; u++) begin
        if (stb.dispEn && stb.dispIdx == TAG_W'(u)) begin
          busyQ[u]    <= 1'b1;
          issuedQ[u]  <= 1'b0;
          doneQ[u]    <= 1'b0;
          hasDestQ[u] <= !dispIsStore;
          opQ[u]      <= dispOp;
          destQ[u]    <= dispDest;
          src1Q[u]    <= dispSrc1;
          src2Q[u]    <= dispSrc2;
          tag1Q[u]    <= newTag1;
          tag2Q[u]    <= newTag2;
          for (int j = 0; j < NUM_UNITS; j++) begin
            olderQ[u][j] <= 1'b0;
            olderQ[j][u] <= (j != u) && busyQ[j] && !stb.wbOh[j];
          end
        end else begin
          if (stb.wbOh[u]) begin
            busyQ[u]   <= 1'b0;
            issuedQ[u] <= 1'b0;
            doneQ[u]   <= 1'b0;
          end else begin
            if (stb.issueOh[u]) issuedQ[u] <= 1'b1;
            if (doneIn[u] && busyQ[u] && issuedQ[u]) doneQ[u] <= 1'b1;
          end
          tag1Q[u] <= liveTag(tag1Q[u], stb.wbOh);
          tag2Q[u] <= liveTag(tag2Q[u], stb.wbOh);
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_UNITS; g++) begin : gChk
    AST_FREE_AFTER_WB: assert property (@(posedge clk) disable iff (!rstN)
      stb.wbOh[g] && !(stb.dispEn && stb.dispIdx == TAG_W'(g)) |=> !busyQ[g]); // R9
    AST_ISSUE_FROM_WAITING: assert property (@(posedge clk) disable iff (!rstN)
      stb.issueOh[g] |-> busyQ[g] && !issuedQ[g]); // R5
    AST_DISPATCH_FILLS: assert property (@(posedge clk) disable iff (!rstN)
      stb.dispEn && stb.dispIdx == TAG_W'(g) |=> busyQ[g] && !issuedQ[g]); // R2
  end
endmodule

// File: rtl/sb_control.sv
module sb_control
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic clk,
  input  logic rstN,
  input  logic dispValid,
  input  logic [1:0] dispClass,
  input  logic [TAG_W-1:0] destStat,
  input  logic [NUM_UNITS-1:0] doneIn,
  input  logic [NUM_UNITS-1:0] busyQ,
  input  logic [NUM_UNITS-1:0] issuedQ,
  input  logic [NUM_UNITS-1:0] doneQ,
  input  logic [NUM_UNITS-1:0] hasDestQ,
  input  logic [NUM_UNITS-1:0][REG_W-1:0] destQ,
  input  logic [NUM_UNITS-1:0][REG_W-1:0] src1Q,
  input  logic [NUM_UNITS-1:0][REG_W-1:0] src2Q,
  input  logic [NUM_UNITS-1:0][TAG_W-1:0] tag1Q,
  input  logic [NUM_UNITS-1:0][TAG_W-1:0] tag2Q,
  input  logic [NUM_UNITS-1:0][NUM_UNITS-1:0] olderQ,
  output sbStrobes_t stb,
  output logic dispIsStore,
  output logic dispStall,
  output logic [TAG_W-1:0] dispTag
);
  unitClass_e cls;
  logic [NUM_UNITS-1:0] wbOh, issueOh, readyV, freeV;
  logic [TAG_W-1:0] want;
  logic dispEn;

  function automatic logic tagReady(input logic [TAG_W-1:0] t,
                                    input logic [NUM_UNITS-1:0] wb);
    tagReady = (t == '0);
    for (int u = 0; u < NUM_UNITS; u++)
      if (wb[u] && t == TAG_W'(u + 1)) tagReady = 1'b1;
  endfunction

  // Writeback: completed units, held on a pending read of the old value.
  always_comb begin
    wbOh = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      logic pend, war;
      pend = busyQ[u] && issuedQ[u] && (doneQ[u] || doneIn[u]);
      war  = 1'b0;
      for (int j = 0; j < NUM_UNITS; j++)
        if (j != u && hasDestQ[u] && busyQ[j] && !issuedQ[j] &&
            ((src1Q[j] == destQ[u] && tag1Q[j] == '0) ||
             (src2Q[j] == destQ[u] && tag2Q[j] == '0)))
          war = 1'b1;
      wbOh[u] = pend && !war;
    end
  end

  // Issue: oldest entry whose operands are ready.
  always_comb begin
    for (int u = 0; u < NUM_UNITS; u++)
      readyV[u] = busyQ[u] && !issuedQ[u] &&
                  tagReady(tag1Q[u], wbOh) && tagReady(tag2Q[u], wbOh);
    for (int u = 0; u < NUM_UNITS; u++) begin
      logic blocked;
      blocked = 1'b0;
      for (int j = 0; j < NUM_UNITS; j++)
        if (readyV[j] && olderQ[j][u]) blocked = 1'b1;
      issueOh[u] = readyV[u] && !blocked;
    end
  end

  // Dispatch: structural and write-after-write checks.
  always_comb begin
    cls         = unitClass_e'(dispClass);
    freeV       = ~busyQ | wbOh;
    dispIsStore = (cls == CLS_ST);
    if (cls == CLS_FP) want = freeV[U_FP1] ? TAG_W'(U_FP1) : TAG_W'(U_FP2);
    else               want = TAG_W'(dispClass);
    dispStall = dispValid && (!freeV[want] || (!dispIsStore && destStat != '0));
    dispEn    = dispValid && !dispStall;
    dispTag   = want + TAG_W'(1);
    stb.dispEn  = dispEn;
    stb.dispIdx = want;
    stb.issueOh = issueOh;
    stb.wbOh    = wbOh;
  end

  AST_ONE_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(issueOh)); // R5
  AST_NO_WAW_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    dispEn && !dispIsStore |-> destStat == '0); // R3
  for (genvar g = 0; g < NUM_UNITS; g++) begin : gWb
    AST_WB_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
      wbOh[g] |-> busyQ[g] && issuedQ[g]); // R7
  end
endmodule

// File: rtl/scoreboard_ctrl.sv
module scoreboard_ctrl
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int OP_W = 4,
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic clk,
  input  logic rstN,
  input  logic dispValid,
  input  logic [1:0] dispClass,
  input  logic [OP_W-1:0] dispOp,
  input  logic [REG_W-1:0] dispDest,
  input  logic [REG_W-1:0] dispSrc1,
  input  logic [REG_W-1:0] dispSrc2,
  input  logic [NUM_UNITS-1:0] doneIn,
  output logic dispStall,
  output logic [TAG_W-1:0] dispTag,
  output logic [NUM_UNITS-1:0] issueStrobe,
  output logic [OP_W-1:0] issueOp,
  output logic [REG_W-1:0] issueSrc1,
  output logic [REG_W-1:0] issueSrc2,
  output logic [NUM_UNITS-1:0] wbGrant
);
  sbStrobes_t stb;
  logic dispIsStore;
  logic [TAG_W-1:0] destStat;
  logic [NUM_UNITS-1:0] busyQ, issuedQ, doneQ, hasDestQ;
  logic [NUM_UNITS-1:0][OP_W-1:0] opQ;
  logic [NUM_UNITS-1:0][REG_W-1:0] destQ, src1Q, src2Q;
  logic [NUM_UNITS-1:0][TAG_W-1:0] tag1Q, tag2Q;
  logic [NUM_UNITS-1:0][NUM_UNITS-1:0] olderQ;

  sb_control #(.NUM_REGS(NUM_REGS)) uCtrl (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispClass(dispClass),
    .destStat(destStat), .doneIn(doneIn), .busyQ(busyQ), .issuedQ(issuedQ),
    .doneQ(doneQ), .hasDestQ(hasDestQ), .destQ(destQ), .src1Q(src1Q),
    .src2Q(src2Q), .tag1Q(tag1Q), .tag2Q(tag2Q), .olderQ(olderQ),
    .stb(stb), .dispIsStore(dispIsStore), .dispStall(dispStall), .dispTag(dispTag)
  );

  sb_tables #(.NUM_REGS(NUM_REGS), .OP_W(OP_W)) uTables (
    .clk(clk), .rstN(rstN), .stb(stb), .dispIsStore(dispIsStore),
    .dispOp(dispOp), .dispDest(dispDest), .dispSrc1(dispSrc1), .dispSrc2(dispSrc2),
    .doneIn(doneIn), .busyQ(busyQ), .issuedQ(issuedQ), .doneQ(doneQ),
    .hasDestQ(hasDestQ), .opQ(opQ), .destQ(destQ), .src1Q(src1Q), .src2Q(src2Q),
    .tag1Q(tag1Q), .tag2Q(tag2Q), .olderQ(olderQ), .destStat(destStat)
  );

  assign issueStrobe = stb.issueOh;
  assign wbGrant     = stb.wbOh;

  always_comb begin
    issueOp = '0; issueSrc1 = '0; issueSrc2 = '0;
    for (int u = 0; u < NUM_UNITS; u++)
      if (stb.issueOh[u]) begin
        issueOp   = issueOp | opQ[u];
        issueSrc1 = issueSrc1 | src1Q[u];
        issueSrc2 = issueSrc2 | src2Q[u];
      end
  end
endmodule

// File: tb/scoreboard_ctrl_test.sv
module scoreboard_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 32;
  localparam int OPW = 4;
  localparam int RW = 5;
  localparam int NU = 5;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic rstN, dispValid, dispStall;
  logic [1:0] dispClass;
  logic [OPW-1:0] dispOp, issueOp;
  logic [RW-1:0] dispDest, dispSrc1, dispSrc2, issueSrc1, issueSrc2;
  logic [NU-1:0] doneIn, issueStrobe, wbGrant;
  logic [2:0] dispTag;

  scoreboard_ctrl #(.NUM_REGS(NREG), .OP_W(OPW)) uut (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispClass(dispClass),
    .dispOp(dispOp), .dispDest(dispDest), .dispSrc1(dispSrc1), .dispSrc2(dispSrc2),
    .doneIn(doneIn), .dispStall(dispStall), .dispTag(dispTag),
    .issueStrobe(issueStrobe), .issueOp(issueOp), .issueSrc1(issueSrc1),
    .issueSrc2(issueSrc2), .wbGrant(wbGrant)
  );

  // Behavioural reference state
  int mBusy[NU], mIss[NU], mDone[NU], mHasDest[NU], mOp[NU], mDest[NU];
  int mS1[NU], mS2[NU], mT1[NU], mT2[NU], mAge[NU], cnt[NU], spur[NU];
  int mReg[NREG];
  int lat[NU] = '{1, 2, 1, 3, 3};
  int seqNo, checks, errors;
  int qc[$], qd[$], qs1[$], qs2[$], qo[$];
  int eStall, eWaw, eTag, eT1, eT2, best;
  int eWb[NU], eWar[NU];

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int tagOk(input int t);
    return (t == 0) || (eWb[t-1] != 0);
  endfunction

  function automatic int anyBusy();
    for (int u = 0; u < NU; u++) if (mBusy[u] != 0 || cnt[u] != 0) return 1;
    return 0;
  endfunction

  task automatic push(input int c, input int d, input int a, input int b, input int o);
    qc.push_back(c); qd.push_back(d); qs1.push_back(a); qs2.push_back(b); qo.push_back(o);
  endtask

  task automatic drive(input int bubblePct, input int spurPct);
    dispValid = (qc.size() > 0) && (($urandom % 100) >= bubblePct);
    if (dispValid) begin
      dispClass = 2'(qc[0]); dispDest = RW'(qd[0]); dispSrc1 = RW'(qs1[0]);
      dispSrc2 = RW'(qs2[0]); dispOp = OPW'(qo[0]);
    end else begin
      dispClass = 2'($urandom); dispDest = RW'($urandom); dispSrc1 = RW'($urandom);
      dispSrc2 = RW'($urandom); dispOp = OPW'($urandom);
    end
    for (int u = 0; u < NU; u++) begin
      spur[u] = (cnt[u] == 0) && (($urandom % 100) < spurPct);
      doneIn[u] = (cnt[u] == 1) || (spur[u] != 0);
    end
  endtask

  task automatic modelComb();
    int free[NU];
    int want, st, t;
    for (int u = 0; u < NU; u++) begin
      int pend, war;
      pend = mBusy[u] && mIss[u] && (mDone[u] || doneIn[u]);
      war = 0;
      if (mHasDest[u] != 0)
        for (int j = 0; j < NU; j++)
          if (j != u && mBusy[j] && !mIss[j] &&
              ((mS1[j] == mDest[u] && mT1[j] == 0) || (mS2[j] == mDest[u] && mT2[j] == 0)))
            war = 1;
      eWar[u] = pend && war;
      eWb[u] = pend && !war;
    end
    for (int u = 0; u < NU; u++) free[u] = !mBusy[u] || eWb[u];
    eStall = 0; eWaw = 0; eTag = 0;
    if (dispValid) begin
      want = (dispClass == 3) ? (free[3] ? 3 : 4) : int'(dispClass);
      st = (dispClass == 2);
      eWaw = !st && mReg[dispDest] != 0;
      eStall = !free[want] || eWaw;
      eTag = want + 1;
      t = mReg[dispSrc1]; if (t != 0 && eWb[t-1]) t = 0; eT1 = t;
      t = mReg[dispSrc2]; if (t != 0 && eWb[t-1]) t = 0; eT2 = t;
    end
    best = -1;
    for (int u = 0; u < NU; u++)
      if (mBusy[u] && !mIss[u] && tagOk(mT1[u]) && tagOk(mT2[u]))
        if (best < 0 || mAge[u] < mAge[best]) best = u;
  endtask

  task automatic compareOut();
    string r;
    r = !dispValid ? "R2" : (dispClass == 2) ? "R10" : (eWaw != 0) ? "R3" : "R2";
    chk(r, "dispStall", int'(dispStall), eStall);
    if (dispValid && !eStall) chk("R2", "dispTag", int'(dispTag), eTag);
    for (int u = 0; u < NU; u++) begin
      r = (mBusy[u] && !mIss[u] && !(tagOk(mT1[u]) && tagOk(mT2[u]))) ? "R4" : "R5";
      chk(r, $sformatf("issueStrobe[%0d]", u), int'(issueStrobe[u]), int'(best == u));
    end
    if (best >= 0) begin
      chk("R6", "issueOp", int'(issueOp), mOp[best]);
      chk("R6", "issueSrc1", int'(issueSrc1), mS1[best]);
      chk("R6", "issueSrc2", int'(issueSrc2), mS2[best]);
    end
    for (int u = 0; u < NU; u++) begin
      r = (u == 2) ? "R10" : (eWar[u] != 0) ? "R8" : (spur[u] != 0) ? "R7" : "R9";
      chk(r, $sformatf("wbGrant[%0d]", u), int'(wbGrant[u]), eWb[u]);
    end
  endtask

  task automatic modelCommit();
    int w;
    for (int u = 0; u < NU; u++)
      if (eWb[u]) begin
        if (mHasDest[u]) mReg[mDest[u]] = 0;
        mBusy[u] = 0; mIss[u] = 0; mDone[u] = 0;
      end
    for (int u = 0; u < NU; u++) begin
      if (mT1[u] != 0 && eWb[mT1[u]-1]) mT1[u] = 0;
      if (mT2[u] != 0 && eWb[mT2[u]-1]) mT2[u] = 0;
      if (!eWb[u]) begin
        if (doneIn[u] && mBusy[u] && mIss[u]) mDone[u] = 1;
        if (best == u) mIss[u] = 1;
      end
      if (best == u) cnt[u] = lat[u];
      else if (cnt[u] > 0) cnt[u]--;
    end
    if (dispValid && !eStall) begin
      w = eTag - 1;
      mBusy[w] = 1; mIss[w] = 0; mDone[w] = 0;
      mHasDest[w] = (dispClass != 2);
      mOp[w] = dispOp; mDest[w] = dispDest; mS1[w] = dispSrc1; mS2[w] = dispSrc2;
      mT1[w] = eT1; mT2[w] = eT2; mAge[w] = seqNo++;
      if (mHasDest[w]) mReg[dispDest] = eTag;
      void'(qc.pop_front()); void'(qd.pop_front()); void'(qs1.pop_front());
      void'(qs2.pop_front()); void'(qo.pop_front());
    end
  endtask

  task automatic run(input int bubblePct, input int spurPct);
    int cyc;
    cyc = 0;
    while ((qc.size() > 0 || anyBusy() != 0) && cyc < 20000) begin
      @(negedge clk);
      drive(bubblePct, spurPct);
      #1;
      modelComb();
      compareOut();
      @(posedge clk);
      modelCommit();
      cyc++;
    end
    if (cyc >= 20000) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not drain, actual=%0d expected<%0d cycles", cyc, 20000);
    end
  endtask

  initial begin
    checks = 0; errors = 0; seqNo = 0;
    for (int u = 0; u < NU; u++) begin
      mBusy[u] = 0; mIss[u] = 0; mDone[u] = 0; mHasDest[u] = 0; mOp[u] = 0;
      mDest[u] = 0; mS1[u] = 0; mS2[u] = 0; mT1[u] = 0; mT2[u] = 0;
      mAge[u] = 0; cnt[u] = 0; spur[u] = 0; eWb[u] = 0; eWar[u] = 0;
    end
    for (int r = 0; r < NREG; r++) mReg[r] = 0;
    rstN = 1'b0; dispValid = 1'b0; dispClass = '0; dispOp = '0;
    dispDest = '0; dispSrc1 = '0; dispSrc2 = '0; doneIn = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1", "reset issueStrobe", int'(issueStrobe), 0);
    chk("R1", "reset wbGrant", int'(wbGrant), 0);
    chk("R1", "reset dispStall", int'(dispStall), 0);

    // Two passes of a load / multiply / store / pointer-increment loop
    for (int k = 0; k < 2; k++) begin
      push(1, 2, 4, 4, 1);
      push(3, 3, 1, 2, 2);
      push(2, 9, 3, 4, 3);
      push(0, 4, 4, 4, 4);
    end
    run(0, 0);

    // FP burst: three FP instructions, third must wait for a free FP unit
    push(3, 10, 13, 13, 5);
    push(3, 11, 13, 13, 6);
    push(3, 12, 10, 11, 7);
    push(2, 10, 12, 12, 8);
    run(0, 0);

    // Dense random traffic over few registers, with bubbles and stray pulses
    for (int k = 0; k < 600; k++)
      push(int'($urandom % 4), int'($urandom % 8), int'($urandom % 8),
           int'($urandom % 8), int'($urandom % 16));
    run(20, 10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule